// File: doc/BRIEF.md
# Two-Register I2C Configuration Target

This block is an I2C target that sits on a two-wire serial bus and holds two 8-bit configuration registers for the surrounding chip. It answers one fixed 7-bit device address. It oversamples SCL and SDA with the faster system clock, and it pulls SDA low through an active-high open-drain enable. It never drives the line high.

A write transaction carries the control byte, a register-select byte and one or two data bytes. With two data bytes the write runs from the selected register to the next one. A read transaction carries only the control byte, and the target then returns the register that the last accepted select byte pointed at. Written bytes wait in shadow storage. They reach the parallel outputs only when the transaction ends with STOP, so the rest of the chip never sees a half-written pair.

Top module: `cfg_i2c_target`

## Requirements
- R1: After reset SDA is released (`sda_oe` = 0), both outputs hold their reset values (0x00 by default), and the register pointer selects register 0.
- R2: A control byte whose upper seven bits equal 1000110 is acknowledged (SDA pulled low during the ninth clock). Any other address is not acknowledged, and every later byte of that transaction is neither acknowledged nor stored.
- R3: In a write, the byte after the control byte selects a register: 0x00 selects register 0 (`cfg0_q`) and 0x01 selects register 1 (`cfg1_q`). Either value is acknowledged and loads the pointer. Any other value is not acknowledged, leaves the pointer unchanged, and the rest of the transaction is ignored.
- R4: A single data byte after a valid select byte is acknowledged and is written to the selected register.
- R5: Consecutive data bytes go to consecutive registers, starting at the selected one. A data byte that would go past register 1 is not acknowledged and is discarded.
- R6: The outputs change only on the cycle after a STOP is detected. A START that arrives before the STOP discards all pending written bytes.
- R7: With R/W = 1, the target shifts out the committed register at the pointer, most significant bit first. After a master ACK it sends the same register again. After a master NACK it keeps SDA released until the next START.
- R8: A START (SDA falling while SCL is high) restarts address decoding in any state and releases SDA. A STOP (SDA rising while SCL is high) ends the transaction.
- R9: The target changes its SDA enable only while the synchronized SCL is low, apart from releasing it at START or STOP.
- R10: Data bytes do not move the pointer. A read after a two-byte write from 0x00 returns register 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| cfg0_q | output | 8 | Committed value of register 0 |
| cfg1_q | output | 8 | Committed value of register 1 |

## Verification
A bus edge takes two synchronizer clocks and one registered decision, so the SDA enable answers an SCL fall within three system clocks. A STOP reaches the outputs within the same delay. The bench holds every SCL phase for ten system clocks. It samples acknowledge and read bits in the middle of the SCL-high phase, and it reads the outputs at least ten clocks after STOP, so each result has settled before it is compared. Before STOP, the check that nothing has moved is made while SCL is low, once the last data byte has already been acknowledged.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;
   localparam int unsigned BYTE_W   = 8;
   localparam int unsigned NUM_REGS = 2;
   localparam int unsigned PTR_W    = 1;

   typedef logic [BYTE_W-1:0] byte_t;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_CTRL,
      PH_REGSEL,
      PH_WDATA,
      PH_RDATA,
      PH_SKIP
   } phase_e;
endpackage

// File: rtl/cfg_i2c_line_sync.sv
module cfg_i2c_line_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] chain_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= RST_VAL;
            else        chain_q[s] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= RST_VAL;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/cfg_i2c_frontend.sv
module cfg_i2c_frontend #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_s, sda_s, scl_d, sda_d;

   cfg_i2c_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .din(scl_i), .dout(scl_s));
   cfg_i2c_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .din(sda_i), .dout(sda_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   assign scl_lvl   = scl_s;
   assign sda_lvl   = sda_s;
   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/cfg_i2c_regbank.sv
module cfg_i2c_regbank
   import cfg_i2c_pkg::*;
#(
   parameter int unsigned                     REGS     = NUM_REGS,
   parameter logic [REGS-1:0][BYTE_W-1:0]     RST_VALS = '0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [PTR_W-1:0]              wr_idx,
   input  byte_t                         wr_data,
   input  logic                          commit,
   input  logic                          discard,
   output logic [REGS-1:0][BYTE_W-1:0]   q,
   output logic [REGS-1:0]               pending
);
   if (REGS > (1 << PTR_W)) begin : g_bad_regs
      $error("regbank: REGS exceeds pointer range");
   end

   for (genvar r = 0; r < REGS; r++) begin : g_reg
      byte_t shadow_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            shadow_q   <= '0;
            pending[r] <= 1'b0;
            q[r]       <= RST_VALS[r];
         end else if (discard) begin
            pending[r] <= 1'b0;
         end else if (commit) begin
            if (pending[r]) q[r] <= shadow_q;
            pending[r] <= 1'b0;
         end else if (wr_en && (wr_idx == PTR_W'(r))) begin
            shadow_q   <= wr_data;
            pending[r] <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/cfg_i2c_engine.sv
module cfg_i2c_engine
   import cfg_i2c_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'b1000110
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            scl_rise,
   input  logic                            scl_fall,
   input  logic                            sda_lvl,
   input  logic                            start_det,
   input  logic                            stop_det,
   input  logic [NUM_REGS-1:0][BYTE_W-1:0] rd_q,
   output logic                            sda_oe,
   output logic                            wr_en,
   output logic [PTR_W-1:0]                wr_idx,
   output byte_t                           wr_data,
   output phase_e                          phase
);
   localparam int unsigned CNT_W     = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);
   localparam byte_t SEL_LIMIT       = byte_t'(NUM_REGS);
   localparam logic [PTR_W:0] WLIMIT = (PTR_W+1)'(NUM_REGS);

   phase_e            phase_q, nxt_q, dec_next;
   logic              ack_ph_q, oe_q, dec_ack, byte_done, active;
   logic [CNT_W-1:0]  cnt_q;
   byte_t             sh_q, tx_q;
   logic [PTR_W-1:0]  ptr_q;
   logic [PTR_W:0]    widx_q;

   assign active    = (phase_q != PH_IDLE) && (phase_q != PH_SKIP);
   assign byte_done = active && scl_fall && !ack_ph_q && (cnt_q == LAST);

   always_comb begin
      dec_ack  = 1'b0;
      dec_next = PH_SKIP;
      unique case (phase_q)
         PH_CTRL: if (sh_q[BYTE_W-1:1] == DEV_ADDR) begin
            dec_ack  = 1'b1;
            dec_next = sh_q[0] ? PH_RDATA : PH_REGSEL;
         end
         PH_REGSEL: if (sh_q < SEL_LIMIT) begin
            dec_ack  = 1'b1;
            dec_next = PH_WDATA;
         end
         PH_WDATA: if (widx_q < WLIMIT) begin
            dec_ack  = 1'b1;
            dec_next = PH_WDATA;
         end
         PH_RDATA: dec_next = PH_RDATA;
         default: ;
      endcase
   end

   assign wr_en   = byte_done && (phase_q == PH_WDATA) && dec_ack;
   assign wr_idx  = widx_q[PTR_W-1:0];
   assign wr_data = sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= PH_IDLE;
         nxt_q    <= PH_IDLE;
         ack_ph_q <= 1'b0;
         oe_q     <= 1'b0;
         cnt_q    <= '0;
         sh_q     <= '0;
         tx_q     <= '0;
         ptr_q    <= '0;
         widx_q   <= '0;
      end else if (start_det) begin
         phase_q  <= PH_CTRL;
         ack_ph_q <= 1'b0;
         cnt_q    <= '0;
         oe_q     <= 1'b0;
      end else if (stop_det) begin
         phase_q  <= PH_IDLE;
         ack_ph_q <= 1'b0;
         cnt_q    <= '0;
         oe_q     <= 1'b0;
      end else if (active) begin
         if (scl_rise) begin
            if (!ack_ph_q) begin
               cnt_q <= cnt_q + 1'b1;
               sh_q  <= {sh_q[BYTE_W-2:0], sda_lvl};
            end else if ((phase_q == PH_RDATA) && sda_lvl) begin
               nxt_q <= PH_SKIP;
            end
         end else if (scl_fall) begin
            if (ack_ph_q) begin
               ack_ph_q <= 1'b0;
               cnt_q    <= '0;
               phase_q  <= nxt_q;
               if (nxt_q == PH_RDATA) begin
                  tx_q <= rd_q[ptr_q];
                  oe_q <= ~rd_q[ptr_q][BYTE_W-1];
               end else begin
                  oe_q <= 1'b0;
               end
            end else if (cnt_q == LAST) begin
               ack_ph_q <= 1'b1;
               nxt_q    <= dec_next;
               oe_q     <= dec_ack;
               if ((phase_q == PH_REGSEL) && dec_ack) begin
                  ptr_q  <= sh_q[PTR_W-1:0];
                  widx_q <= {1'b0, sh_q[PTR_W-1:0]};
               end
               if (wr_en) widx_q <= widx_q + 1'b1;
            end else if ((phase_q == PH_RDATA) && (cnt_q != '0)) begin
               tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
               oe_q <= ~tx_q[BYTE_W-2];
            end
         end
      end
   end

   assign sda_oe = oe_q;
   assign phase  = phase_q;
endmodule

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target
   import cfg_i2c_pkg::*;
#(
   parameter logic [6:0]        DEV_ADDR    = 7'b1000110,
   parameter int unsigned       SYNC_STAGES = 2,
   parameter logic [BYTE_W-1:0] CFG0_RST    = 8'h00,
   parameter logic [BYTE_W-1:0] CFG1_RST    = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   output logic [BYTE_W-1:0] cfg0_q,
   output logic [BYTE_W-1:0] cfg1_q
);
   localparam logic [NUM_REGS-1:0][BYTE_W-1:0] RST_VALS = {CFG1_RST, CFG0_RST};

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("cfg_i2c_target: SYNC_STAGES must be at least 2");
   end
   if (NUM_REGS != 2) begin : g_bad_count
      $error("cfg_i2c_target: exactly two registers are exposed");
   end

   logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
   logic wr_en;
   logic [PTR_W-1:0] wr_idx;
   byte_t wr_data;
   phase_e phase;
   logic [NUM_REGS-1:0][BYTE_W-1:0] regs_q;
   logic [NUM_REGS-1:0] pending;

   cfg_i2c_frontend #(.SYNC_STAGES(SYNC_STAGES)) u_front (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det));

   cfg_i2c_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
      .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .sda_lvl(sda_lvl), .start_det(start_det), .stop_det(stop_det),
      .rd_q(regs_q), .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .phase(phase));

   cfg_i2c_regbank #(.REGS(NUM_REGS), .RST_VALS(RST_VALS)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .commit(stop_det), .discard(start_det),
      .q(regs_q), .pending(pending));

   assign cfg0_q = regs_q[0];
   assign cfg1_q = regs_q[1];
endmodule

// File: rtl/cfg_i2c_target_chk.sv
module cfg_i2c_target_chk
   import cfg_i2c_pkg::*;
(
   input logic                clk,
   input logic                rst_n,
   input logic                scl_lvl,
   input logic                start_det,
   input logic                stop_det,
   input logic                sda_oe,
   input logic [BYTE_W-1:0]   cfg0_q,
   input logic [BYTE_W-1:0]   cfg1_q,
   input logic [NUM_REGS-1:0] pending,
   input phase_e              phase
);
   assert_hold_until_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !stop_det |=> ($stable(cfg0_q) && $stable(cfg1_q)));

   assert_discard_on_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (pending == '0));

   assert_steady_scl_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_lvl && !start_det && !stop_det) |=> $stable(sda_oe));

   assert_release_on_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> !sda_oe);

   // Covers R7 as well: after a master NACK the engine rests in PH_SKIP.
   assert_quiet_when_unaddressed_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((phase == PH_IDLE) || (phase == PH_SKIP)) |-> !sda_oe);
endmodule

bind cfg_i2c_target cfg_i2c_target_chk u_chk (
   .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .start_det(start_det),
   .stop_det(stop_det), .sda_oe(sda_oe), .cfg0_q(cfg0_q), .cfg1_q(cfg1_q),
   .pending(pending), .phase(phase));

// File: tb/test_cfg_i2c_target.sv
module test_cfg_i2c_target;
   localparam int Q = 10;

   typedef struct packed {
      logic [7:0] ra;
      logic [1:0] nd;
      logic [7:0] d0, d1, d2;
      logic [3:0] acks;
      logic [7:0] e0, e1, erd;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{8'h00, 2'd1, 8'hA5, 8'h00, 8'h00, 4'b1100, 8'hA5, 8'h00, 8'hA5},
      '{8'h01, 2'd1, 8'h3C, 8'h00, 8'h00, 4'b1100, 8'hA5, 8'h3C, 8'h3C},
      '{8'h00, 2'd2, 8'h11, 8'h22, 8'h00, 4'b1110, 8'h11, 8'h22, 8'h11},
      '{8'h00, 2'd3, 8'h44, 8'h55, 8'h66, 4'b1110, 8'h44, 8'h55, 8'h44},
      '{8'h01, 2'd2, 8'h77, 8'h88, 8'h00, 4'b1100, 8'h44, 8'h77, 8'h77},
      '{8'h02, 2'd1, 8'h99, 8'h00, 8'h00, 4'b0000, 8'h44, 8'h77, 8'h77},
      '{8'hFF, 2'd0, 8'h00, 8'h00, 8'h00, 4'b0000, 8'h44, 8'h77, 8'h77}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1;
   logic m_sda = 1'b1;
   logic sda_oe;
   logic [7:0] cfg0, cfg1;
   wire  sda_line = m_sda & ~sda_oe;
   int   n_chk = 0;
   int   n_err = 0;
   bit   oe_moved = 1'b0;
   bit   done = 1'b0;

   always #5 clk = ~clk;

   cfg_i2c_target i_cfg_i2c_target (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
      .sda_oe(sda_oe), .cfg0_q(cfg0), .cfg1_q(cfg1));

   task automatic hold(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_start();
      m_sda = 1'b1; hold(Q);
      m_scl = 1'b1; hold(Q);
      m_sda = 1'b0; hold(Q);
      m_scl = 1'b0; hold(Q);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; hold(Q);
      m_scl = 1'b1; hold(Q);
      m_sda = 1'b1; hold(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic acked);
      logic oe0;
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i]; hold(Q);
         m_scl = 1'b1; hold(Q);
         m_scl = 1'b0;
      end
      m_sda = 1'b1; hold(Q);
      m_scl = 1'b1; hold(1);
      oe0 = sda_oe;
      hold(Q/2);
      acked = ~sda_line;
      hold(Q/2 - 1);
      if (sda_oe !== oe0) oe_moved = 1'b1;
      m_scl = 1'b0;
   endtask

   task automatic recv_byte(input logic mack, output logic [7:0] b);
      m_sda = 1'b1;
      b = '0;
      for (int i = 0; i < 8; i++) begin
         hold(Q);
         m_scl = 1'b1; hold(Q/2);
         b = {b[6:0], sda_line};
         hold(Q/2);
         m_scl = 1'b0;
      end
      m_sda = ~mack; hold(Q);
      m_scl = 1'b1; hold(Q);
      m_scl = 1'b0; hold(2);
      m_sda = 1'b1;
   endtask

   task automatic read_once(input string req, input logic [7:0] exp);
      logic a;
      logic [7:0] v;
      bus_start();
      send_byte(8'h8D, a);
      check({req, " R2 read ctrl ack"}, {7'd0, a}, 8'h01);
      recv_byte(1'b0, v);
      check(req, v, exp);
      bus_stop();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog expired actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      logic a;
      logic [7:0] v;
      hold(4);
      rst_n = 1'b1;
      hold(4);
      check("R1 sda released", {7'd0, sda_oe}, 8'h00);
      check("R1 cfg0 reset", cfg0, 8'h00);
      check("R1 cfg1 reset", cfg1, 8'h00);
      read_once("R1 R7 read pointer after reset", 8'h00);

      for (int i = 0; i < NV; i++) begin
         vec_t vv;
         logic [7:0] d;
         vv = VECS[i];
         bus_start();
         send_byte(8'h8C, a);
         check("R2 write ctrl ack", {7'd0, a}, 8'h01);
         send_byte(vv.ra, a);
         check("R3 select ack", {7'd0, a}, {7'd0, vv.acks[3]});
         for (int k = 0; k < int'(vv.nd); k++) begin
            d = (k == 0) ? vv.d0 : ((k == 1) ? vv.d1 : vv.d2);
            send_byte(d, a);
            check("R4 R5 data ack", {7'd0, a}, {7'd0, vv.acks[2-k]});
         end
         bus_stop();
         check("R4 R5 cfg0 after stop", cfg0, vv.e0);
         check("R4 R5 cfg1 after stop", cfg1, vv.e1);
         read_once("R7 R10 read at pointer", vv.erd);
      end

      // R2: foreign address, later bytes ignored
      bus_start();
      send_byte(8'h8E, a);
      check("R2 foreign addr nack", {7'd0, a}, 8'h00);
      send_byte(8'h00, a);
      check("R2 select after foreign addr nack", {7'd0, a}, 8'h00);
      send_byte(8'hAB, a);
      check("R2 data after foreign addr nack", {7'd0, a}, 8'h00);
      bus_stop();
      check("R2 cfg0 unchanged", cfg0, 8'h44);
      check("R2 cfg1 unchanged", cfg1, 8'h77);

      // R6 / R8: pending write dropped by repeated START
      bus_start();
      send_byte(8'h8C, a);
      send_byte(8'h00, a);
      send_byte(8'h5A, a);
      check("R6 data ack before restart", {7'd0, a}, 8'h01);
      hold(Q);
      check("R6 cfg0 unchanged before stop", cfg0, 8'h44);
      bus_start();
      send_byte(8'h8D, a);
      check("R8 ctrl decoded after restart", {7'd0, a}, 8'h01);
      recv_byte(1'b1, v);
      check("R7 first read byte", v, 8'h44);
      recv_byte(1'b0, v);
      check("R7 repeat same register", v, 8'h44);
      hold(2*Q);
      check("R7 released after master nack", {7'd0, sda_oe}, 8'h00);
      bus_stop();
      check("R6 discarded pending byte", cfg0, 8'h44);

      // R4: single write to register 1
      bus_start();
      send_byte(8'h8C, a);
      send_byte(8'h01, a);
      send_byte(8'hC3, a);
      bus_stop();
      check("R4 cfg1 single write", cfg1, 8'hC3);
      check("R4 cfg0 untouched", cfg0, 8'h44);

      check("R9 sda stable while scl high", {7'd0, oe_moved}, 8'h00);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule